// File: doc/BRIEF.md
# PWM Channel with External Clear

This block is one channel of an up-counting timer. A free-running counter steps from zero up to a programmable auto-reload value, then wraps to zero and raises a one-cycle overflow pulse. A per-channel reference waveform is derived from the counter and a programmable compare value. The waveform's behaviour depends on a mode select: it can hold its level, be set high, set low or toggled when the counter reaches the compare value, be forced high or low, or run as an edge-aligned PWM.

A level-sensitive clear can pull the reference low. The clear comes from one of two sources: a dedicated clear pin, or a trigger line that has already been filtered upstream. A select bit picks the source, and an enable bit allows the clear to act at all. Once the clear has been seen, the reference stays low for the rest of the counter period. It is released only when the counter wraps at a moment when the selected clear source is low. The clear has no effect while the channel is in a forced mode.

Top module: `pwm_clr_channel`

## Requirements
- R1: While `rst_n` is low, `cnt_o`, `ovf_o` and `ref_o` are all 0.
- R2: At each edge the counter loads 0 if its value is greater than or equal to `arr_i`; otherwise it loads its value plus 1. `ovf_o` is 1 in exactly those cycles that follow a wrap, and in each of them `cnt_o` is 0.
- R3: With `mode_i` = 6 (PWM mode 1), `ref_o` is 1 in a cycle exactly when `cnt_o` < `cmp_i`, provided no clear is active. With `cmp_i` = 0 the output is always 0.
- R4: When `clr_en_i` = 1, the mode is not forced, and the selected clear source is 1 at an edge, `ref_o` is 0 from the next cycle on.
- R5: A clear is sticky. After the source returns to 0, `ref_o` stays 0 until the counter wraps with the source at 0 at that edge. From the following cycle the output again follows the mode.
- R6: If the clear source is still 1 at the wrap edge, `ref_o` stays 0 for the whole next period.
- R7: `clr_sel_i` = 0 takes the clear from `clr_pin_i`, and `clr_sel_i` = 1 takes it from `trig_i`. The source that is not selected has no effect on `ref_o`.
- R8: `mode_i` = 4 drives `ref_o` to 0 and `mode_i` = 5 drives it to 1, both from the cycle after the mode is applied. In these modes the clear inputs have no effect.
- R9: With `clr_en_i` = 0, both clear inputs are ignored and `ref_o` follows the mode unaltered.
- R10: With `cmp_i` > `arr_i` in mode 6, `ref_o` is constantly 1. After a clear it returns to 1 in the cycle after the next wrap.
- R11: The output-compare modes act in the cycle in which `cnt_o` becomes `cmp_i`. `mode_i` = 1 sets the reference to 1, 2 sets it to 0 and 3 inverts it. `mode_i` = 0 (and the spare code 7) keeps the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| arr_i | input | W | Auto-reload (top count) value |
| cmp_i | input | W | Compare value |
| mode_i | input | 3 | Output mode: 0 hold, 1 set on match, 2 reset on match, 3 toggle on match, 4 force low, 5 force high, 6 PWM mode 1, 7 hold |
| clr_en_i | input | 1 | Enables the external clear |
| clr_sel_i | input | 1 | Clear source select: 0 pin, 1 filtered trigger |
| clr_pin_i | input | 1 | Dedicated clear input |
| trig_i | input | 1 | Filtered external trigger, usable as clear |
| cnt_o | output | W | Current counter value |
| ovf_o | output | 1 | One-cycle pulse in the cycle after a wrap |
| ref_o | output | 1 | Reference waveform after clear gating |

## Verification
A sticky clear flag that is stuck at its value shows up at `ref_o` in one of two ways. It either fails to fall on the first edge at which the selected source is high, or it fails to recover in the cycle after the first clean wrap. Either way the error appears within one counter period. A counter or compare fault shifts the PWM edges, and it becomes visible at `cnt_o`, `ovf_o` or `ref_o` on the very next cycle. The bench therefore compares all three outputs against a behavioural model on every cycle. Clear pulses are placed in both the high and the low phase of the waveform, across a wrap, in forced modes and with the clear disabled.

// File: rtl/pwm_clr_pkg.sv
package pwm_clr_pkg;

  typedef enum logic [2:0] {
    OC_HOLD     = 3'd0,
    OC_SET      = 3'd1,
    OC_RESET    = 3'd2,
    OC_TOGGLE   = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM1     = 3'd6,
    OC_SPARE    = 3'd7
  } oc_mode_e;

  // Clear gating applies in every mode except the two forced ones.
  function automatic logic mode_clearable(oc_mode_e m);
    return !((m == OC_FORCE_LO) || (m == OC_FORCE_HI));
  endfunction

endpackage

// File: rtl/pwm_clr_counter.sv
module pwm_clr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] arr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         wrap;

  // next-state
  always_comb begin
    wrap  = (cnt_q >= arr_i);
    cnt_d = wrap ? '0 : cnt_q + STEP;
    ovf_d = wrap;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign wrap_o    = wrap;
  assign ovf_o     = ovf_q;

  // R2: a wrap condition always lands on zero
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= arr_i) |=> (cnt_q == '0));
  // R2: overflow pulse only ever seen with counter at zero
  assert_ovf_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_clr_refgen.sv
module pwm_clr_refgen
  import pwm_clr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  oc_mode_e     mode_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cnt_nxt_i,
  output logic         ref_o
);
  logic ref_q, ref_d, ref_ld;
  logic hit;

  // next-state: the reference is aligned with the counter value being loaded
  always_comb begin
    hit    = (cnt_nxt_i == cmp_i);
    ref_d  = ref_q;
    ref_ld = 1'b1;
    unique case (mode_i)
      OC_SET:      ref_d = hit ? 1'b1 : ref_q;
      OC_RESET:    ref_d = hit ? 1'b0 : ref_q;
      OC_TOGGLE:   ref_d = hit ? ~ref_q : ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM1:     ref_d = (cnt_nxt_i < cmp_i);
      default:     ref_ld = 1'b0;  // hold and spare code
    endcase
  end

  // registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else if (ref_ld) begin
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;

  // R8: forced-high mode makes the raw reference high one edge later
  assert_force_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OC_FORCE_HI) |=> ref_q);
  // R3: compare value zero in PWM mode 1 yields a low reference
  assert_pwm_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == OC_PWM1) && (cmp_i == '0)) |=> !ref_q);

endmodule

// File: rtl/pwm_clr_clrctl.sv
module pwm_clr_clrctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_en_i,
  input  logic clr_sel_i,
  input  logic clr_pin_i,
  input  logic trig_i,
  input  logic clearable_i,
  input  logic wrap_i,
  output logic gate_o
);
  logic src, armed;
  logic clr_q, clr_d;

  // next-state: sticky flag, released only at a wrap with the source low
  always_comb begin
    src   = clr_sel_i ? trig_i : clr_pin_i;
    armed = clr_en_i & clearable_i;
    clr_d = clr_q;
    if (!armed)      clr_d = 1'b0;
    else if (src)    clr_d = 1'b1;
    else if (wrap_i) clr_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
    end
  end

  assign gate_o = clr_q & armed;

  // R4: a seen clear sets the flag
  assert_clear_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && clearable_i && (clr_sel_i ? trig_i : clr_pin_i)) |=> clr_q);
  // R5: the flag is held until a wrap while still enabled
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !wrap_i && clr_en_i && clearable_i) |=> clr_q);

endmodule

// File: rtl/pwm_clr_channel.sv
module pwm_clr_channel
  import pwm_clr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] arr_i,
  input  logic [W-1:0] cmp_i,
  input  logic [2:0]   mode_i,
  input  logic         clr_en_i,
  input  logic         clr_sel_i,
  input  logic         clr_pin_i,
  input  logic         trig_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         ref_o
);
  oc_mode_e     mode;
  logic [W-1:0] cnt_nxt;
  logic         wrap;
  logic         ref_raw;
  logic         gate;
  logic         clearable;

  assign mode      = oc_mode_e'(mode_i);
  assign clearable = mode_clearable(mode);

  pwm_clr_counter #(.W(W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_i     (arr_i),
    .cnt_o     (cnt_o),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap),
    .ovf_o     (ovf_o)
  );

  pwm_clr_refgen #(.W(W)) i_refgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .cmp_i     (cmp_i),
    .cnt_nxt_i (cnt_nxt),
    .ref_o     (ref_raw)
  );

  pwm_clr_clrctl i_clrctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_en_i    (clr_en_i),
    .clr_sel_i   (clr_sel_i),
    .clr_pin_i   (clr_pin_i),
    .trig_i      (trig_i),
    .clearable_i (clearable),
    .wrap_i      (wrap),
    .gate_o      (gate)
  );

  assign ref_o = ref_raw & ~gate;

  // R1: reset state at the outputs
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (ref_o == 1'b0 && ovf_o == 1'b0 && cnt_o == '0);
    end
  end

endmodule

// File: tb/test_pwm_clr_channel.sv
`timescale 1ns/1ps
module test_pwm_clr_channel;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] arr, cmp;
  logic [2:0]   mode;
  logic         clr_en, clr_sel, clr_pin, trig;
  logic [W-1:0] cnt_o;
  logic         ovf_o, ref_o;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_clr_channel #(.W(W)) i_pwm_clr_channel (
    .clk(clk), .rst_n(rst_n), .arr_i(arr), .cmp_i(cmp), .mode_i(mode),
    .clr_en_i(clr_en), .clr_sel_i(clr_sel), .clr_pin_i(clr_pin), .trig_i(trig),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .ref_o(ref_o)
  );

  // behavioural reference model
  int m_cnt, m_ref, m_clr, m_ovf;

  function automatic bit forced(input logic [2:0] md);
    return (md == 3'd4) || (md == 3'd5);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ref = 0; m_clr = 0; m_ovf = 0;
    end else begin
      int  n;
      bit  wr;
      bit  s;
      wr = (m_cnt >= int'(arr));
      n  = wr ? 0 : m_cnt + 1;
      case (mode)
        3'd1: if (n == int'(cmp)) m_ref = 1;
        3'd2: if (n == int'(cmp)) m_ref = 0;
        3'd3: if (n == int'(cmp)) m_ref = 1 - m_ref;
        3'd4: m_ref = 0;
        3'd5: m_ref = 1;
        3'd6: m_ref = (n < int'(cmp)) ? 1 : 0;
        default: ;
      endcase
      s = clr_sel ? trig : clr_pin;
      if (!clr_en || forced(mode)) m_clr = 0;
      else if (s)                  m_clr = 1;
      else if (wr)                 m_clr = 0;
      m_cnt = n;
      m_ovf = wr;
    end
  end

  function automatic logic exp_ref();
    return (m_ref != 0) && !((m_clr != 0) && clr_en && !forced(mode));
  endfunction

  task automatic compare();
    vectors++;
    if (cnt_o !== W'(m_cnt) || ovf_o !== 1'(m_ovf) || ref_o !== exp_ref()) begin
      miscompares++;
      $display("FAIL %s: cnt/ovf/ref actual %0d/%0b/%0b expected %0d/%0b/%0b",
               cur_req, cnt_o, ovf_o, ref_o, m_cnt, m_ovf, exp_ref());
    end
  endtask

  task automatic expect_ref(input string req, input logic exp);
    vectors++;
    if (ref_o !== exp) begin
      miscompares++;
      $display("FAIL %s: ref_o actual %0b expected %0b", req, ref_o, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    int lfsr;
    rst_n = 1'b0;
    arr = 8'd9; cmp = 8'd4; mode = 3'd6;
    clr_en = 1'b0; clr_sel = 1'b0; clr_pin = 1'b0; trig = 1'b0;
    #12;
    // R1 reset state
    cur_req = "R1";
    @(negedge clk);
    compare();
    expect_ref("R1", 1'b0);
    rst_n = 1'b1;

    // R2 / R3 plain PWM
    cur_req = "R2 R3";
    run(35);
    cmp = 8'd7; run(22);
    cur_req = "R3 cmp0";
    cmp = 8'd0; run(22);
    expect_ref("R3", 1'b0);

    // R4 / R5 single clear pulse in the high phase
    cmp = 8'd6; clr_en = 1'b1; clr_sel = 1'b0;
    run(11);
    cur_req = "R4 R5";
    clr_pin = 1'b1; run(1);
    clr_pin = 1'b0; run(25);

    // R6 clear held across a wrap
    cur_req = "R6";
    clr_pin = 1'b1; run(14);
    clr_pin = 1'b0; run(22);

    // R7 source select
    cur_req = "R7 pin ignored";
    clr_sel = 1'b1;
    run(12); clr_pin = 1'b1; run(3); clr_pin = 1'b0; run(10);
    cur_req = "R7 trig used";
    trig = 1'b1; run(2); trig = 1'b0; run(20);
    clr_sel = 1'b0;

    // R9 clear disabled
    cur_req = "R9";
    clr_en = 1'b0;
    run(11); clr_pin = 1'b1; run(4); clr_pin = 1'b0; run(10);
    clr_en = 1'b1;

    // R10 full duty
    cur_req = "R10";
    cmp = 8'd20; run(12);
    expect_ref("R10", 1'b1);
    clr_pin = 1'b1; run(1); clr_pin = 1'b0; run(25);

    // R8 forced modes with clear asserted
    cur_req = "R8 force high";
    mode = 3'd5; clr_pin = 1'b1; run(6);
    expect_ref("R8", 1'b1);
    cur_req = "R8 force low";
    mode = 3'd4; run(6);
    expect_ref("R8", 1'b0);
    clr_pin = 1'b0;

    // R11 output-compare match modes
    cmp = 8'd3;
    cur_req = "R11 set";    mode = 3'd1; run(22);
    cur_req = "R11 reset";  mode = 3'd2; run(22);
    cur_req = "R11 toggle"; mode = 3'd3; run(32);
    cur_req = "R11 hold";   mode = 3'd0; run(15);
    mode = 3'd7; run(12);
    cur_req = "R11 R4 toggle clear";
    mode = 3'd3; clr_pin = 1'b1; run(2); clr_pin = 1'b0; run(25);

    // mixed stimulus: R2 R4 R5 R6 R7 R9 R10
    cur_req = "R5 R7 mixed";
    lfsr = 32'h1d3a;
    for (int k = 0; k < 1500; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      if ((k % 150) == 0) begin
        arr  = W'(5 + (lfsr % 11));
        cmp  = W'(lfsr % 18);
        mode = 3'((lfsr >> 4) % 8);
        clr_en  = ((lfsr >> 7) & 3) != 0;
        clr_sel = (lfsr >> 9) & 1;
      end
      clr_pin = ((lfsr & 15) == 3);
      trig    = ((lfsr & 31) == 9);
      run(1);
    end

    done = 1'b1;
    finish_up();
  end
endmodule